// File: doc/BRIEF.md
# Flag register transfer unit

This block holds the 16-bit status-flag word of a processor core and carries out the four transfers that move it. It can copy the low flag byte into an 8-bit accumulator-high register. It can load the low flag byte from that register. It can push the whole flag word onto a memory stack, and it can pop the word back. The block keeps the stack pointer itself, and a simple synchronous word-wide memory port carries the stack traffic.

An operation is selected on `op` and launched with a one-cycle `start` strobe while the unit is idle. The byte transfers finish in one cycle. Push and pop each spend two busy cycles. The first push cycle moves the stack pointer down by two and the second writes the word. The first pop cycle presents the address with a read request and the second captures the returned word. A one-cycle `done` pulse marks the end of every operation. The flag word keeps carry at bit 0, parity at 2, auxiliary carry at 4, zero at 6, sign at 7, trap at 8, interrupt enable at 9, direction at 10 and overflow at 11. The remaining bits are constants.

Top module: `flag_xfer_unit`

## Requirements
- R1: After reset, `flags` is 16'h0002, `sp` equals the parameter SP_RESET (default 16'h0100), `ah_out` is 0, and `done`, `busy`, `mem_we` and `mem_re` are 0.
- R2: Op 2'b00 (copy to register) sets `ah_out` to `flags[7:0]` and leaves `flags` and `sp` unchanged.
- R3: Op 2'b01 (load from register) sets `flags[7:0]` to `(ah_in & 8'hD5) | 8'h02` and leaves `flags[15:8]` and `sp` unchanged.
- R4: Op 2'b10 (push) lowers `sp` by 2 in its first busy cycle. In its second busy cycle it asserts `mem_we` with `mem_addr` equal to the new `sp` and `mem_wdata` equal to `flags`. `flags` is unchanged.
- R5: Op 2'b11 (pop) asserts `mem_re` with `mem_addr` equal to `sp` in its first busy cycle. It then loads `flags` with `(mem_rdata & 16'h0FD5) | 16'h0002` and raises `sp` by 2. It never writes memory, so the stacked word is left intact.
- R6: Bits 1, 3, 5 and 12 to 15 of `flags` always read as 1, 0, 0 and 0, whatever is loaded.
- R7: `done` is a single-cycle pulse. It is high in the first cycle after the start edge for op 00 and op 01, and in the third cycle after the start edge for push and pop.
- R8: A `start` seen while `busy` is high is ignored, and the running operation completes unchanged.
- R9: `mem_we` and `mem_re` are never high together, and each is high for exactly one cycle per push or pop respectively, never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| op | input | 2 | 00 copy to register, 01 load from register, 10 push, 11 pop |
| ah_in | input | 8 | Accumulator-high value for the load operation |
| ah_out | output | 8 | Accumulator-high value written by the copy operation |
| flags | output | 16 | Current flag word |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | High while a push or pop is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 16 | Stack memory write data |
| mem_rdata | input | 16 | Stack memory read data, valid the cycle after `mem_re` |
| mem_we | output | 1 | Stack memory write enable |
| mem_re | output | 1 | Stack memory read enable |

## Verification
Random sequences of the four operations are run with random register bytes and random stack contents. Pops return words with the constant bits set wrongly, which separates masked loads from raw ones. Push-then-pop chains show whether the stack pointer moves by two in the right cycle, and whether the address comes before or after the adjustment. Loads that follow pops with random upper halves show whether the control flags survive a byte load. Directed cases strobe `start` in mid-push and load all-ones and all-zeros bytes, which shows whether a busy strobe and the constant bits are really ignored.

// File: rtl/flag_xfer_unit.sv
module flag_xfer_unit #(
  parameter logic [15:0] SP_RESET   = 16'h0100,
  parameter logic [15:0] KEEP_MASK  = 16'h0FD5,
  parameter logic [15:0] FIXED_ONES = 16'h0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [7:0]  ah_in,
  output logic [7:0]  ah_out,
  output logic [15:0] flags,
  output logic [15:0] sp,
  output logic        busy,
  output logic        done,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        mem_we,
  output logic        mem_re
);

  typedef enum logic [2:0] {S_IDLE, S_PUSH_DEC, S_PUSH_WR, S_POP_RD, S_POP_LD} state_t;
  state_t state;

  function automatic logic [15:0] clean(input logic [15:0] w);
    return (w & KEEP_MASK) | FIXED_ONES;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      flags  <= FIXED_ONES;
      sp     <= SP_RESET;
      ah_out <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          case (op)
            2'b00: begin ah_out <= flags[7:0]; done <= 1'b1; end
            2'b01: begin flags <= clean({flags[15:8], ah_in}); done <= 1'b1; end
            2'b10: state <= S_PUSH_DEC;
            default: state <= S_POP_RD;
          endcase
        end
        S_PUSH_DEC: begin sp <= sp - 16'd2; state <= S_PUSH_WR; end
        S_PUSH_WR:  begin state <= S_IDLE; done <= 1'b1; end
        S_POP_RD:   state <= S_POP_LD;
        S_POP_LD: begin
          flags <= clean(mem_rdata);
          sp    <= sp + 16'd2;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign mem_addr  = sp;
  assign mem_wdata = flags;
  assign mem_we    = (state == S_PUSH_WR);
  assign mem_re    = (state == S_POP_RD);

endmodule

// File: rtl/flag_xfer_unit_chk.sv
module flag_xfer_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  op,
  input logic [15:0] flags,
  input logic [15:0] sp,
  input logic        busy,
  input logic        done,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_we,
  input logic        mem_re
);

  p_fixed_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 16'hF02A) == 16'h0002);

  p_load_keeps_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 2'b01) |=> flags[15:8] == $past(flags[15:8]));

  p_push_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == sp && mem_wdata == flags && $past(busy)));

  p_pop_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ##1 (sp == $past(sp, 2) + 16'd2));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_idle_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sp) && !busy);

endmodule

bind flag_xfer_unit flag_xfer_unit_chk u_chk (.*);

// File: tb/flag_xfer_unit_bench.sv
module flag_xfer_unit_bench;
  localparam time CLK_PERIOD = 10;
  localparam logic [15:0] SPR = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] ah_in = 8'h00, ah_out;
  logic [15:0] flags, sp, mem_addr, mem_wdata, mem_rdata;
  logic busy, done, mem_we, mem_re;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [15:0] mem [0:255];
  logic [15:0] exp_mem [0:255];
  logic [15:0] e_flags, e_sp;
  logic [7:0]  e_ah;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_xfer_unit #(.SP_RESET(SPR)) u_flag_xfer_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ah_in(ah_in),
    .ah_out(ah_out), .flags(flags), .sp(sp), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_re(mem_re));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[8:1]];
  end

  function automatic logic [15:0] fix(input logic [15:0] w);
    return (w & 16'h0FD5) | 16'h0002;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [7:0] a, input bit poke);
    int lat, we_n, re_n;
    logic [15:0] rd_addr;
    @(negedge clk);
    op = o; ah_in = a; start = 1'b1;
    lat = 0; we_n = 0; re_n = 0; rd_addr = 16'hxxxx;
    case (o)
      2'b00: e_ah = e_flags[7:0];
      2'b01: e_flags = {e_flags[15:8], fix({8'h00, a})[7:0]};
      2'b10: begin e_sp = e_sp - 16'd2; exp_mem[e_sp[8:1]] = e_flags; end
      default: begin rd_addr = e_sp; e_flags = fix(exp_mem[e_sp[8:1]]); e_sp = e_sp + 16'd2; end
    endcase
    do begin
      @(negedge clk);
      lat++;
      start = (poke && lat == 1);
      op = 2'b00;
      if (mem_we) begin
        we_n++;
        chk("R4 push addr", {16'h0, mem_addr}, {16'h0, e_sp});
        chk("R4 push data", {16'h0, mem_wdata}, {16'h0, e_flags});
        chk("R4 push slot", lat, 2);
      end
      if (mem_re) begin
        re_n++;
        chk("R5 pop addr", {16'h0, mem_addr}, {16'h0, rd_addr});
        chk("R5 pop slot", lat, 1);
      end
      chk("R9 we/re exclusive", {31'h0, mem_we & mem_re}, 0);
    end while (!done && lat < 10);
    start = 1'b0;
    chk("R7 done latency", lat, (o[1] ? 3 : 1));
    chk("R9 write count", we_n, (o == 2'b10) ? 1 : 0);
    chk("R9 read count", re_n, (o == 2'b11) ? 1 : 0);
    chk(o == 2'b11 ? "R5 pop flags" : o == 2'b01 ? "R3 load flags" : "R2 flags kept",
        {16'h0, flags}, {16'h0, e_flags});
    chk(poke ? "R8 busy start ignored ah" : "R2 ah_out", {24'h0, ah_out}, {24'h0, e_ah});
    chk("R4 R5 sp", {16'h0, sp}, {16'h0, e_sp});
    chk("R6 fixed bits", {16'h0, flags & 16'hF02A}, 32'h0002);
    if (o == 2'b11) chk("R5 stack word intact", {16'h0, mem[rd_addr[8:1]]}, {16'h0, exp_mem[rd_addr[8:1]]});
    @(negedge clk);
    chk("R7 done single", {31'h0, done}, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'($urandom);
      exp_mem[i] = mem[i];
    end
    e_flags = 16'h0002; e_sp = SPR; e_ah = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", {16'h0, flags}, 32'h0002);
    chk("R1 sp", {16'h0, sp}, {16'h0, SPR});
    chk("R1 ah_out", {24'h0, ah_out}, 0);
    chk("R1 strobes", {28'h0, done, busy, mem_we, mem_re}, 0);

    run_op(2'b01, 8'hFF, 0);
    run_op(2'b00, 8'h00, 0);
    run_op(2'b01, 8'h00, 0);
    mem[(SPR >> 1) & 16'hFF] = 16'hFFFF; exp_mem[(SPR >> 1) & 16'hFF] = 16'hFFFF;
    run_op(2'b11, 8'h00, 0);
    run_op(2'b01, 8'h00, 0);
    run_op(2'b10, 8'h00, 0);
    run_op(2'b01, 8'hAA, 0);
    run_op(2'b00, 8'h00, 0);
    run_op(2'b10, 8'h00, 1);
    run_op(2'b11, 8'h00, 1);
    run_op(2'b11, 8'h00, 0);

    for (int n = 0; n < 300; n++)
      run_op(2'($urandom), 8'($urandom), ($urandom % 5) == 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule